// File: doc/BRIEF.md
# Noise-Shaping Word-Length Reducer

This block narrows a signed sample stream that runs at four times its base rate. Each incoming word is summed with the residual left over from the previous conversion and with a small triangular random offset. The sum is then rounded to the coarser output grid. The new residual is the gap between the pre-rounding value and the emitted word, expressed in input LSBs. It is stored and folded into the next sample. This first-order error-feedback loop moves the rounding noise away from low frequencies and toward the top of the oversampled band, where a later decimator can remove it.

One sample enters per `in_en` pulse and one narrowed word leaves on the next clock. At full scale the output saturates to the narrow signed range. Whenever that happens, the stored residual is clamped to one output step so that an overload cannot build up inside the loop. By default the block takes 16-bit words and produces 14-bit words, which means one output LSB equals four input LSBs.

Top module: `nsq_requant`

## Requirements
- R1: While `rst` is high, `y_out` is 0, `y_valid` is 0 and the stored residual is cleared. Each reset also returns both dither generators to fixed seeds, so the same input after two separate resets yields the same output sequence.
- R2: `y_valid` is high in exactly the cycle after a cycle with `in_en` high, and is low in every other cycle.
- R3: For a constant input x, the 16 outputs in any aligned block satisfy |4·Σy − 16·x| ≤ 10 input LSBs. This holds because the residual (pre-rounding value minus 4·y) is added to the next input and stays within ±5 input LSBs.
- R4: For a constant input x, the mean of 4096 outputs is within 0.05 output LSB of x/4.
- R5: The dither is the sum of two uniform 2-bit values taken from two independent LFSRs, recentred to the range −3..+3 input LSBs. With x = 0 held at the input, the output is not always zero.
- R6: Outputs saturate to the 14-bit signed range. With x = 32767 held, every output is 8190 or 8191. With x = −32768 held, every output lies in −8192..−8190.
- R7: In a cycle that saturates, the stored residual is clamped to ±4 input LSBs (one output LSB). After a long overload, a step to x = 0 yields |y| ≤ 2 from the very first output.
- R8: Without `in_en`, `y_out` and the loop state hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | One-cycle pulse that marks a valid input sample |
| in_x | input | 16 | Signed input sample |
| y_out | output | 14 | Signed narrowed sample |
| y_valid | output | 1 | High for one cycle when `y_out` has been updated |

## Verification
The assertions assume that reset is applied before the first sample and that `in_en` and `in_x` are always driven to known levels. Under those assumptions, the residual bound of ±5 input LSBs follows from the dither range alone and holds for any input value. The stimulus drives inputs on the falling edge and keeps `in_en` to single-cycle pulses separated by an idle cycle. Overload is produced only at the two extreme input codes, and the DC accuracy runs use values far enough from the rails that rounding never saturates.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

    localparam int unsigned DEF_IN_W   = 16;
    localparam int unsigned DEF_OUT_W  = 14;
    localparam int unsigned LFSR_W     = 16;
    localparam int unsigned N_DITHER   = 2;

    typedef enum logic [1:0] {
        OVL_NONE = 2'b00,
        OVL_HIGH = 2'b01,
        OVL_LOW  = 2'b10
    } ovl_e;

    typedef struct packed {
        logic [LFSR_W-1:0] taps;
        logic [LFSR_W-1:0] seed;
    } lfsr_cfg_t;

    function automatic lfsr_cfg_t lfsr_cfg(input int idx);
        lfsr_cfg_t c;
        if (idx == 0) begin
            c.taps = 16'hB400;
            c.seed = 16'hACE1;
        end else begin
            c.taps = 16'hD008;
            c.seed = 16'h1D2B;
        end
        return c;
    endfunction

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

endpackage

// File: rtl/nsq_dither.sv
module nsq_dither
    import nsq_pkg::*;
#(
    parameter int unsigned SHIFT = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    step,
    output logic signed [SHIFT+1:0] dith
);
    localparam int unsigned DW   = SHIFT + 2;
    localparam int          DMAX = (1 << SHIFT) - 1;

    logic [LFSR_W-1:0] state [N_DITHER];
    logic [DW-1:0]     uni   [N_DITHER];

    for (genvar g = 0; g < N_DITHER; g++) begin : g_lfsr
        localparam lfsr_cfg_t CFG = lfsr_cfg(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                state[g] <= CFG.seed;
            end else if (step) begin
                state[g] <= state[g][0] ? ((state[g] >> 1) ^ CFG.taps) : (state[g] >> 1);
            end
        end
        assign uni[g] = DW'(state[g][SHIFT-1:0]);
    end

    always_comb begin
        dith = $signed(uni[0] + uni[1]) - $signed(DW'(DMAX));
    end

endmodule

// File: rtl/nsq_quant.sv
module nsq_quant
    import nsq_pkg::*;
#(
    parameter int unsigned IN_W  = DEF_IN_W,
    parameter int unsigned OUT_W = DEF_OUT_W
) (
    input  logic signed [IN_W-1:0]          x,
    input  logic signed [IN_W-OUT_W+1:0]    err,
    input  logic signed [IN_W-OUT_W+1:0]    dith,
    output logic signed [OUT_W-1:0]         y,
    output logic signed [IN_W-OUT_W+1:0]    err_nxt,
    output ovl_e                            ovl
);
    localparam int unsigned SHIFT = IN_W - OUT_W;
    localparam int unsigned ERR_W = SHIFT + 2;
    localparam int unsigned EW    = IN_W + 2;
    localparam int          ONE   = 1 << SHIFT;
    localparam logic signed [EW-1:0] HALF    = EW'(1 << (SHIFT - 1));
    localparam logic signed [EW-1:0] OUT_MAX = EW'((1 << (OUT_W - 1)) - 1);
    localparam logic signed [EW-1:0] OUT_MIN = -EW'(1 << (OUT_W - 1));

    logic signed [EW-1:0] v, w, q, y_ext, e_full;
    int                   e_lim;

    always_comb begin
        v = EW'(x) + EW'(err);
        w = v + EW'(dith) + HALF;
        q = w >>> SHIFT;
        if (q > OUT_MAX) begin
            ovl   = OVL_HIGH;
            y_ext = OUT_MAX;
        end else if (q < OUT_MIN) begin
            ovl   = OVL_LOW;
            y_ext = OUT_MIN;
        end else begin
            ovl   = OVL_NONE;
            y_ext = q;
        end
        e_full = v - (y_ext <<< SHIFT);
        if (ovl != OVL_NONE) begin
            e_lim = clamp_int(int'(e_full), -ONE, ONE);
        end else begin
            e_lim = int'(e_full);
        end
        err_nxt = ERR_W'(e_lim);
        y       = y_ext[OUT_W-1:0];
    end

endmodule

// File: rtl/nsq_requant.sv
module nsq_requant
    import nsq_pkg::*;
#(
    parameter int unsigned IN_W  = DEF_IN_W,
    parameter int unsigned OUT_W = DEF_OUT_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_en,
    input  logic signed [IN_W-1:0]  in_x,
    output logic signed [OUT_W-1:0] y_out,
    output logic                    y_valid
);
    localparam int unsigned SHIFT   = IN_W - OUT_W;
    localparam int unsigned ERR_W   = SHIFT + 2;
    localparam int          ONE     = 1 << SHIFT;
    localparam int          ERR_LIM = (ONE - 1) + (ONE / 2);

    logic signed [ERR_W-1:0] err_q, err_nxt, dith;
    logic signed [OUT_W-1:0] y_c;
    ovl_e                    ovl;

    nsq_dither #(.SHIFT(SHIFT)) u_dither (
        .clk  (clk),
        .rst  (rst),
        .step (in_en),
        .dith (dith)
    );

    nsq_quant #(.IN_W(IN_W), .OUT_W(OUT_W)) u_quant (
        .x       (in_x),
        .err     (err_q),
        .dith    (dith),
        .y       (y_c),
        .err_nxt (err_nxt),
        .ovl     (ovl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            err_q   <= '0;
            y_out   <= '0;
            y_valid <= 1'b0;
        end else begin
            y_valid <= in_en;
            if (in_en) begin
                err_q <= err_nxt;
                y_out <= y_c;
            end
        end
    end

    // R2: valid strobe tracks the enable one cycle later
    assert_valid_after_en_R2: assert property (@(posedge clk) disable iff (rst)
        in_en |=> y_valid);
    assert_no_valid_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !in_en |=> !y_valid);
    // R8: output and residual hold between samples
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
        !in_en |=> ($stable(y_out) && $stable(err_q)));
    // R3: residual stays inside the dither-derived bound
    assert_err_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (int'(err_q) <= ERR_LIM) && (int'(err_q) >= -ERR_LIM));
    // R7: residual after a saturating sample is within one output step
    assert_sat_clamp_R7: assert property (@(posedge clk) disable iff (rst)
        (in_en && ovl != OVL_NONE) |=> ((int'(err_q) <= ONE) && (int'(err_q) >= -ONE)));

endmodule

// File: tb/nsq_requant_tb.sv
module nsq_requant_tb;
    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 16;
    localparam int OUT_W = 14;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    in_en = 1'b0;
    logic signed [IN_W-1:0]  in_x = '0;
    logic signed [OUT_W-1:0] y_out;
    logic                    y_valid;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nsq_requant #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dut (
        .clk(clk), .rst(rst), .in_en(in_en), .in_x(in_x),
        .y_out(y_out), .y_valid(y_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; in_en = 1'b0; in_x = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic send(input int x, output int y);
        @(negedge clk);
        in_en = 1'b1; in_x = IN_W'(x);
        @(negedge clk);
        in_en = 1'b0;
        y = int'(y_out);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check(y_out == 0, "R1 y_out in reset", int'(y_out), 0);
        check(y_valid == 0, "R1 y_valid in reset", int'(y_valid), 0);
        rst = 1'b0;
    endtask

    task automatic t_timing();
        int held;
        @(negedge clk);
        in_en = 1'b1; in_x = 16'sd400;
        @(posedge clk); #1;
        check(y_valid == 1, "R2 valid after enable", int'(y_valid), 1);
        check(int'(y_out) >= 99 && int'(y_out) <= 101, "R2 value after enable", int'(y_out), 100);
        held = int'(y_out);
        @(negedge clk); in_en = 1'b0; in_x = 16'sd20000;
        @(posedge clk); #1;
        check(y_valid == 0, "R2 valid drops", int'(y_valid), 0);
        repeat (3) @(posedge clk);
        #1;
        check(int'(y_out) == held, "R8 output holds without enable", int'(y_out), held);
        check(y_valid == 0, "R2 no valid while idle", int'(y_valid), 0);
    endtask

    task automatic t_repeat();
        int a [8];
        int b;
        do_reset();
        for (int i = 0; i < 8; i++) send(1234, a[i]);
        do_reset();
        for (int i = 0; i < 8; i++) begin
            send(1234, b);
            check(b == a[i], "R1 reseeded sequence repeats", b, a[i]);
        end
    endtask

    task automatic t_dc(input int x);
        int y, sum, blk, bad_blk, worst;
        longint diff;
        sum = 0; blk = 0; bad_blk = 0; worst = 0;
        for (int i = 0; i < 4096; i++) begin
            send(x, y);
            sum += y; blk += y;
            if ((i % 16) == 15) begin
                int d;
                d = 4 * blk - 16 * x;
                if (d < 0) d = -d;
                if (d > 10) bad_blk++;
                if (d > worst) worst = d;
                blk = 0;
            end
        end
        check(bad_blk == 0, "R3 block error within 10 LSB", worst, 10);
        diff = 64'(4) * sum - 64'(4096) * x;
        if (diff < 0) diff = -diff;
        // 0.05 output LSB = 0.2 input LSB; total over 4096 samples = 819.2
        check(100 * diff <= 20 * 4096, "R4 DC mean accuracy", int'(diff), 819);
    endtask

    task automatic t_dither();
        int y, nz;
        nz = 0;
        for (int i = 0; i < 256; i++) begin
            send(0, y);
            if (y != 0) nz++;
        end
        check(nz > 0, "R5 dither makes zero input toggle", nz, 1);
    endtask

    task automatic t_overload();
        int y, bad_hi, bad_lo, bad_rec, last;
        bad_hi = 0; bad_lo = 0; bad_rec = 0; last = 0;
        for (int i = 0; i < 512; i++) begin
            send(32767, y);
            if (y < 8190 || y > 8191) begin bad_hi++; last = y; end
        end
        check(bad_hi == 0, "R6 positive full scale range", last, 8191);
        for (int i = 0; i < 64; i++) begin
            send(0, y);
            if (y > 2 || y < -2) begin bad_rec++; last = y; end
        end
        check(bad_rec == 0, "R7 recovery after positive overload", last, 0);
        bad_rec = 0;
        for (int i = 0; i < 512; i++) begin
            send(-32768, y);
            if (y < -8192 || y > -8190) begin bad_lo++; last = y; end
        end
        check(bad_lo == 0, "R6 negative full scale range", last, -8192);
        for (int i = 0; i < 64; i++) begin
            send(0, y);
            if (y > 2 || y < -2) begin bad_rec++; last = y; end
        end
        check(bad_rec == 0, "R7 recovery after negative overload", last, 0);
    endtask

    initial begin
        t_reset();
        t_timing();
        t_repeat();
        t_dc(0);
        t_dc(3);
        t_dc(1001);
        t_dc(30001);
        t_dc(-7777);
        t_dither();
        t_overload();
        t_dc(-32000);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule